// File: doc/BRIEF.md
# Bidirectional Printer Port Controller

This block is the register side of an 8-bit parallel printer port that sits behind a CPU register interface. It holds a data register, a control register and an I/O-select register, and it assembles a read-only status register from the printer handshake inputs. It drives the data byte and one output-enable for the data pads. It also drives the level of each of the four control lines, and it reads back the pin level of the three control lines that can be driven from either side.

The direction of the data bus is chosen in one of two ways, selected by the external `mode_sel` input. With `mode_sel` high, one control bit sets the direction. With `mode_sel` low, a byte pattern written to the I/O-select register sets it. The port interrupt comes from the active-low acknowledge input. In follow mode it tracks that input. In latch mode a falling acknowledge sets a flag, and the flag is held until software reads the status register.

Register map (`cpu_addr`): 0 = data, 1 = status (read only, writes have no effect), 2 = control, 3 = I/O-select. Reads are combinational and take effect in the cycle in which `cpu_sel` and `cpu_rd` are high. Writes take effect at the clock edge.

Top module: `prn_port_ctrl`

## Requirements
- R1: After reset the data bus is output (`pd_oe`=1), the control register reads its stored bits as 0, `port_irq` is 0 and the latched interrupt flag is clear.
- R2: With `mode_sel`=1, control bit 5 sets the direction: 0 gives output (`pd_oe`=1) and 1 gives input (`pd_oe`=0). A change shows on `pd_oe` right after the clock edge that writes the control register.
- R3: With `mode_sel`=0, writing 0xAA to the I/O-select register selects input and writing 0x55 selects output. A change shows right after the clock edge of the write.
- R4: Writing any other value to the I/O-select register keeps the direction selected before it.
- R5: With `mode_sel`=1 the I/O-select value has no effect on `pd_oe`. With `mode_sel`=0 control bit 5 has no effect. I/O-select writes made while `mode_sel`=1 are still recorded, and they apply once `mode_sel` returns to 0.
- R6: `pd_out` always shows the data register. A data read returns `pd_in` when the port is input and the data register when it is output.
- R7: In follow mode (control bit 6 = 0) with interrupts enabled, `port_irq` equals the inverse of `ack_n` in the same cycle. Status bit 0 shows the inverse of `ack_n`.
- R8: In latch mode (control bit 6 = 1) a falling edge of `ack_n` sets the flag at the next clock edge. The flag stays set after `ack_n` returns high. A status read clears it at the clock edge that ends the read, and a new falling edge in that same cycle takes priority. Status bit 0 shows the flag.
- R9: Control bit 4 enables the interrupt. When it is 0, `port_irq` is 0 in both modes.
- R10: The status register reads bit 7 = `busy`, bit 6 = `ack_n`, bit 5 = `paper_end`, bit 4 = `select`, bit 3 = `fault` and bit 0 = interrupt indication. Bits 2:1 read 0.
- R11: Control bits 0, 1, 2 and 3 drive `strb_drv`, `afd_drv`, `init_drv` and `slin_drv`. A control read returns `strb_pin`, `afd_pin` and `slin_pin` in bits 0, 1 and 3, and the stored value in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access select |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data |
| mode_sel | input | 1 | Direction mechanism: 1 = control bit, 0 = I/O-select pattern |
| pd_in | input | DATA_W | Data pad input levels |
| pd_out | output | DATA_W | Data pad output value |
| pd_oe | output | 1 | Data pad output enable |
| strb_pin | input | 1 | Strobe line pin level |
| afd_pin | input | 1 | Auto-linefeed line pin level |
| slin_pin | input | 1 | Select-in line pin level |
| strb_drv | output | 1 | Strobe line drive level |
| afd_drv | output | 1 | Auto-linefeed line drive level |
| init_drv | output | 1 | Init line drive level |
| slin_drv | output | 1 | Select-in line drive level |
| ack_n | input | 1 | Acknowledge, active low |
| busy | input | 1 | Printer busy |
| paper_end | input | 1 | Paper end |
| select | input | 1 | Printer selected |
| fault | input | 1 | Printer error |
| port_irq | output | 1 | Port interrupt |

## Verification
A wrong stored direction appears on `pd_oe` straight after the clock edge of the write that should have changed it. It also appears in the value returned by the next data read. If the I/O-select decode were wrong, one table entry with a non-pattern byte would leave `pd_oe` at the wrong level at once. A latched flag that cleared early, or never cleared, appears on `port_irq` one cycle after the acknowledge edge or one cycle after the status read. Follow-mode faults appear combinationally in the same cycle as the `ack_n` change.

// File: rtl/prn_pkg.sv
package prn_pkg;
   localparam int CTL_W = 8;

   typedef enum logic [1:0] {
      REG_DATA   = 2'd0,
      REG_STATUS = 2'd1,
      REG_CTRL   = 2'd2,
      REG_IOSEL  = 2'd3
   } prn_reg_e;

   localparam int B_STRB  = 0;
   localparam int B_AFD   = 1;
   localparam int B_INIT  = 2;
   localparam int B_SLIN  = 3;
   localparam int B_IEN   = 4;
   localparam int B_DIR   = 5;
   localparam int B_LATCH = 6;

   localparam int S_IRQ   = 0;
   localparam int S_FAULT = 3;
   localparam int S_SEL   = 4;
   localparam int S_PE    = 5;
   localparam int S_ACK   = 6;
   localparam int S_BUSY  = 7;
endpackage

// File: rtl/prn_ctl_regs.sv
module prn_ctl_regs #(
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_data,
   input  logic                     wr_ctrl,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        data_q,
   output logic [prn_pkg::CTL_W-1:0] ctrl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_data) data_q <= wdata;
         if (wr_ctrl) ctrl_q <= wdata[prn_pkg::CTL_W-1:0];
      end
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q)); // R11
endmodule

// File: rtl/prn_dir_sel.sv
module prn_dir_sel #(
   parameter logic [7:0] IN_CODE  = 8'hAA,
   parameter logic [7:0] OUT_CODE = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_iosel,
   input  logic [7:0] iosel_byte,
   input  logic       mode_sel,
   input  logic       ctrl_dir,
   output logic       pd_oe
);
   logic sel_in_q;
   logic hit_in, hit_out;

   generate
      if (IN_CODE == OUT_CODE) begin : g_bad_codes
         $error("prn_dir_sel: input and output codes must differ");
      end
   endgenerate

   assign hit_in  = (iosel_byte == IN_CODE);
   assign hit_out = (iosel_byte == OUT_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sel_in_q <= 1'b0;
      else if (wr_iosel && hit_in)  sel_in_q <= 1'b1;
      else if (wr_iosel && hit_out) sel_in_q <= 1'b0;
   end

   assign pd_oe = mode_sel ? !ctrl_dir : !sel_in_q;

   AST_IOSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_iosel && !hit_in && !hit_out) |=> $stable(sel_in_q)); // R4
   AST_IOSEL_TAKE_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_iosel && hit_in && !mode_sel) |=> (mode_sel || !pd_oe)); // R3
   AST_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sel && $past(!mode_sel) && !$past(wr_iosel)) |-> $stable(pd_oe)); // R5
endmodule

// File: rtl/prn_irq.sv
module prn_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic latch_mode,
   input  logic irq_en,
   input  logic ack_n,
   input  logic rd_status,
   output logic irq_status,
   output logic port_irq
);
   logic ack_q;
   logic flag_q;
   logic ack_fall;

   assign ack_fall = ack_q && !ack_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         ack_q <= ack_n;
         if (!latch_mode)    flag_q <= 1'b0;
         else if (ack_fall)  flag_q <= 1'b1;
         else if (rd_status) flag_q <= 1'b0;
      end
   end

   assign irq_status = latch_mode ? flag_q : !ack_n;
   assign port_irq   = irq_en && irq_status;

   AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && ack_fall) |=> flag_q); // R8
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && flag_q && !rd_status) |=> flag_q); // R8
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && rd_status && !ack_fall) |=> !flag_q); // R8
   AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !port_irq); // R9
endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl #(
   parameter int         DATA_W   = 8,
   parameter logic [7:0] IN_CODE  = 8'hAA,
   parameter logic [7:0] OUT_CODE = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [1:0]        cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              mode_sel,
   input  logic [DATA_W-1:0] pd_in,
   output logic [DATA_W-1:0] pd_out,
   output logic              pd_oe,
   input  logic              strb_pin,
   input  logic              afd_pin,
   input  logic              slin_pin,
   output logic              strb_drv,
   output logic              afd_drv,
   output logic              init_drv,
   output logic              slin_drv,
   input  logic              ack_n,
   input  logic              busy,
   input  logic              paper_end,
   input  logic              select,
   input  logic              fault,
   output logic              port_irq
);
   import prn_pkg::*;

   localparam int PAD_W = DATA_W - CTL_W;

   generate
      if (DATA_W < CTL_W) begin : g_bad_width
         $error("prn_port_ctrl: DATA_W must be at least the register width");
      end
   endgenerate

   logic              wr_en, rd_en;
   logic [CTL_W-1:0]  ctrl_q;
   logic [DATA_W-1:0] data_q;
   logic              irq_status;
   logic [CTL_W-1:0]  status_v, ctrl_rb, narrow_rd;

   assign wr_en = cpu_sel && cpu_wr;
   assign rd_en = cpu_sel && cpu_rd;

   prn_ctl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_en && cpu_addr == REG_DATA),
      .wr_ctrl (wr_en && cpu_addr == REG_CTRL),
      .wdata   (cpu_wdata),
      .data_q  (data_q),
      .ctrl_q  (ctrl_q)
   );

   prn_dir_sel #(.IN_CODE(IN_CODE), .OUT_CODE(OUT_CODE)) u_dir (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_iosel   (wr_en && cpu_addr == REG_IOSEL),
      .iosel_byte (cpu_wdata[CTL_W-1:0]),
      .mode_sel   (mode_sel),
      .ctrl_dir   (ctrl_q[B_DIR]),
      .pd_oe      (pd_oe)
   );

   prn_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_mode (ctrl_q[B_LATCH]),
      .irq_en     (ctrl_q[B_IEN]),
      .ack_n      (ack_n),
      .rd_status  (rd_en && cpu_addr == REG_STATUS),
      .irq_status (irq_status),
      .port_irq   (port_irq)
   );

   assign pd_out   = data_q;
   assign strb_drv = ctrl_q[B_STRB];
   assign afd_drv  = ctrl_q[B_AFD];
   assign init_drv = ctrl_q[B_INIT];
   assign slin_drv = ctrl_q[B_SLIN];

   always_comb begin
      status_v          = '0;
      status_v[S_BUSY]  = busy;
      status_v[S_ACK]   = ack_n;
      status_v[S_PE]    = paper_end;
      status_v[S_SEL]   = select;
      status_v[S_FAULT] = fault;
      status_v[S_IRQ]   = irq_status;
      ctrl_rb           = ctrl_q;
      ctrl_rb[B_STRB]   = strb_pin;
      ctrl_rb[B_AFD]    = afd_pin;
      ctrl_rb[B_SLIN]   = slin_pin;
   end

   always_comb begin
      narrow_rd = '0;
      case (cpu_addr)
         REG_STATUS: narrow_rd = status_v;
         REG_CTRL:   narrow_rd = ctrl_rb;
         default:    narrow_rd = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign cpu_rdata = !rd_en ? '0 :
                            (cpu_addr == REG_DATA) ? (pd_oe ? data_q : pd_in) :
                            {{PAD_W{1'b0}}, narrow_rd};
      end else begin : g_nopad
         assign cpu_rdata = !rd_en ? '0 :
                            (cpu_addr == REG_DATA) ? (pd_oe ? data_q : pd_in) :
                            narrow_rd;
      end
   endgenerate

   AST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[B_IEN] && !ctrl_q[B_LATCH]) |-> (port_irq == !ack_n)); // R7
   AST_DATA_RD_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && cpu_addr == REG_DATA && !pd_oe) |-> (cpu_rdata == pd_in)); // R6
endmodule

// File: tb/prn_port_ctrl_bench.sv
module prn_port_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 0, cpu_wr = 0, cpu_rd = 0;
   logic [1:0] cpu_addr = 0;
   logic [7:0] cpu_wdata = 0;
   logic [7:0] cpu_rdata;
   logic       mode_sel = 1;
   logic [7:0] pd_in = 8'h33;
   logic [7:0] pd_out;
   logic       pd_oe;
   logic       strb_pin = 0, afd_pin = 1, slin_pin = 1;
   logic       strb_drv, afd_drv, init_drv, slin_drv;
   logic       ack_n = 1, busy = 0, paper_end = 0, select = 0, fault = 0;
   logic       port_irq;

   int checks = 0;
   int errors = 0;
   logic [7:0] rd;

   always #4 clk = ~clk;

   prn_port_ctrl u_prn_port_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mode_sel(mode_sel), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
      .strb_pin(strb_pin), .afd_pin(afd_pin), .slin_pin(slin_pin),
      .strb_drv(strb_drv), .afd_drv(afd_drv), .init_drv(init_drv), .slin_drv(slin_drv),
      .ack_n(ack_n), .busy(busy), .paper_end(paper_end), .select(select),
      .fault(fault), .port_irq(port_irq)
   );

   // {mode_sel, ctrl, iosel, expected pd_oe}
   localparam logic [17:0] VEC [8] = '{
      {1'b0, 8'h00, 8'hAA, 1'b0},
      {1'b0, 8'h00, 8'h12, 1'b0},
      {1'b0, 8'h20, 8'h55, 1'b1},
      {1'b0, 8'h00, 8'hFF, 1'b1},
      {1'b1, 8'h20, 8'h55, 1'b0},
      {1'b1, 8'h00, 8'hAA, 1'b1},
      {1'b0, 8'h00, 8'h00, 1'b0},
      {1'b1, 8'h20, 8'h55, 1'b0}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 0; cpu_wr = 0;
   endtask

   task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1; cpu_rd = 1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 0; cpu_rd = 0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 oe", {7'd0, pd_oe}, 8'h01);
      chk("R1 irq", {7'd0, port_irq}, 8'h00);
      rst_n = 1;
      cpu_read(2'd2, rd);
      chk("R1 ctrl", rd & 8'hF4, 8'h00);

      // R2 R3 R4 R5 direction table
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         mode_sel = VEC[i][17];
         cpu_write(2'd2, VEC[i][16:9]);
         cpu_write(2'd3, VEC[i][8:1]);
         #1 chk($sformatf("R2/R3/R4/R5 vec%0d", i), {7'd0, pd_oe}, {7'd0, VEC[i][0]});
      end

      // R2 direct: control bit 5 clear gives output
      mode_sel = 1;
      cpu_write(2'd2, 8'h00);
      #1 chk("R2 out", {7'd0, pd_oe}, 8'h01);

      // R6 data path
      cpu_write(2'd0, 8'h5A);
      #1 chk("R6 pd_out", pd_out, 8'h5A);
      cpu_read(2'd0, rd);
      chk("R6 read output", rd, 8'h5A);
      cpu_write(2'd2, 8'h20);
      cpu_read(2'd0, rd);
      chk("R6 read input", rd, 8'h33);
      chk("R6 pd_out kept", pd_out, 8'h5A);

      // R11 control drive and readback
      cpu_write(2'd2, 8'h34);
      #1 chk("R11 drives", {4'd0, slin_drv, init_drv, afd_drv, strb_drv}, 8'h04);
      cpu_read(2'd2, rd);
      chk("R11 readback", rd, 8'h3E);

      // R10 status layout (follow mode, ack low)
      cpu_write(2'd2, 8'h00);
      busy = 1; paper_end = 1; select = 0; fault = 1; ack_n = 0;
      cpu_read(2'd1, rd);
      chk("R10 status", rd, 8'hA9);
      // R9 masked
      chk("R9 mask follow", {7'd0, port_irq}, 8'h00);
      ack_n = 1;

      // R7 follow mode
      cpu_write(2'd2, 8'h10);
      @(negedge clk); ack_n = 0;
      #1 chk("R7 follow low", {7'd0, port_irq}, 8'h01);
      @(negedge clk); ack_n = 1;
      #1 chk("R7 follow high", {7'd0, port_irq}, 8'h00);

      // R8 latch mode
      cpu_write(2'd2, 8'h50);
      @(negedge clk); ack_n = 0;
      @(negedge clk); ack_n = 1;
      #1 chk("R8 set", {7'd0, port_irq}, 8'h01);
      repeat (4) @(negedge clk);
      #1 chk("R8 hold", {7'd0, port_irq}, 8'h01);
      cpu_read(2'd1, rd);
      chk("R8 status flag", rd & 8'h01, 8'h01);
      #1 chk("R8 cleared", {7'd0, port_irq}, 8'h00);

      // R9 latch masked: flag set but irq off
      cpu_write(2'd2, 8'h40);
      @(negedge clk); ack_n = 0;
      @(negedge clk); ack_n = 1;
      #1 chk("R9 mask latch", {7'd0, port_irq}, 8'h00);
      cpu_read(2'd1, rd);
      chk("R8 flag while masked", rd & 8'h01, 8'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule